// File: doc/BRIEF.md
# AES Round Step Unit

This unit carries out one AES round step on a 128-bit state and a 128-bit round key. A 3-bit opcode selects the step. It serves two instruction conventions that divide a round differently. In the fused convention, a full round applies ShiftRows, SubBytes, MixColumns and then the key XOR, and a final-round form drops MixColumns. In the split convention, the key XOR comes first and is followed by ShiftRows and SubBytes, while MixColumns is an opcode of its own. Each step has an inverse counterpart, built for decryption with the equivalent inverse cipher.

Operands enter through a valid/ready handshake. The result sits in a single output register and leaves through a second valid/ready handshake. One step can be accepted every cycle while the consumer keeps up. Key expansion and the sequencing of rounds stay with the caller.

Top module: `aes_round_unit`

## Requirements
- R1: Byte n of a 128-bit operand occupies bits [127-8n:120-8n], so byte 0 is the most significant byte. Byte n sits at row n mod 4 and column n div 4 of the state. ShiftRows rotates row r left by r positions, so result byte (row r, column c) is taken from input column (c+r) mod 4. InvShiftRows rotates each row right by the same amount.
- R2: Opcode 0 (fused round) returns MixColumns(SubBytes(ShiftRows(state))) XOR key. MixColumns uses coefficients {02,03,01,01} over GF(2^8) with polynomial 0x11B.
- R3: Opcode 1 (fused final round) returns SubBytes(ShiftRows(state)) XOR key.
- R4: Opcode 2 (key-first round) returns SubBytes(ShiftRows(state XOR key)).
- R5: Opcode 3 returns MixColumns(state). The key input has no effect on the result.
- R6: Opcode 4 returns InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key, with coefficients {0E,0B,0D,09}. Opcode 5 returns InvSubBytes(InvShiftRows(state)) XOR key.
- R7: Opcode 6 returns InvSubBytes(InvShiftRows(state XOR key)). Opcode 7 returns InvMixColumns(state), and the key input has no effect on the result.
- R8: For any state s and key k, opcode 0 equals opcode 3 applied to opcode 2 with key 0, then XOR k. Opcode 1 equals opcode 2 with key 0, then XOR k. Opcodes 4, 5, 6 and 7 satisfy the same identities among themselves.
- R9: The 128-bit key example of the standard encrypts to 69c4e0d86a7b0430d8cdb78070b4c55a through both the fused and the split conventions. Decryption through both inverse conventions, using round keys passed through InvMixColumns for the middle rounds, returns the plaintext.
- R10: An operand is accepted on a clock edge where in_valid and in_ready are both high. The result shows on out_data with out_valid high after that edge.
- R11: While out_valid is high and out_ready is low, out_valid stays high, out_data holds its value, and in_ready is low.
- R12: While rst_n is low at a clock edge, out_valid is cleared. After reset, in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand |
| in_op | input | 3 | Step opcode (0 to 7, see R2 to R7) |
| in_state | input | 128 | State operand, byte 0 in the top byte |
| in_key | input | 128 | Round key operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Step result |

## Verification
A wrong S-box entry, a rotation error in a shifted row or a wrong mixing coefficient shows up in out_data one cycle after the operand is accepted. Because such faults touch only some bytes, the checks compare every opcode against an independent model under random operands. A full ten-round encryption and decryption chains the steps, so any single fault spreads through later rounds into the final block. A fault in the handshake register shows within the stall cycles: out_data or out_valid changes while out_ready is low, or in_ready is asserted while a result is still held.

// File: rtl/aes_rnd_pkg.sv
// aes_rnd_pkg: shared sizes, opcodes and GF(2^8) helpers for the AES round
// step unit. Assumes byte 0 of a block is its most significant byte.
package aes_rnd_pkg;
    localparam int BYTE_W = 8;
    localparam int NROWS  = 4;
    localparam int NCOLS  = 4;
    localparam int NBYTES = NROWS * NCOLS;
    localparam int BLK_W  = NBYTES * BYTE_W;
    localparam int COL_W  = NROWS * BYTE_W;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_ENC     = 3'd0;
    localparam logic [OP_W-1:0] OP_ENCLAST = 3'd1;
    localparam logic [OP_W-1:0] OP_KFIRST  = 3'd2;
    localparam logic [OP_W-1:0] OP_MIX     = 3'd3;
    localparam logic [OP_W-1:0] OP_DEC     = 3'd4;
    localparam logic [OP_W-1:0] OP_DECLAST = 3'd5;
    localparam logic [OP_W-1:0] OP_KFIRSTI = 3'd6;
    localparam logic [OP_W-1:0] OP_IMIX    = 3'd7;

    // multiply by x modulo 0x11B
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // general GF(2^8) product by shift and add
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254 (zero maps to zero)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        r = 8'h01;
        p = a;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
        return (a << n) | (a >> (8 - n));
    endfunction

    // forward substitution: inverse then affine map
    function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    // inverse substitution: inverse affine map then inverse
    function automatic logic [7:0] sbox_inv(input logic [7:0] a);
        return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
    endfunction

    // one column through MixColumns (inv=0) or InvMixColumns (inv=1)
    function automatic logic [COL_W-1:0] col_mix(input logic [COL_W-1:0] col, input logic inv);
        logic [7:0] a [NROWS];
        logic [7:0] c [NROWS];
        logic [COL_W-1:0] res;
        c[0] = inv ? 8'h0E : 8'h02;
        c[1] = inv ? 8'h0B : 8'h03;
        c[2] = inv ? 8'h0D : 8'h01;
        c[3] = inv ? 8'h09 : 8'h01;
        for (int r = 0; r < NROWS; r++) a[r] = col[COL_W-1-8*r -: 8];
        res = '0;
        for (int r = 0; r < NROWS; r++) begin
            res[COL_W-1-8*r -: 8] = gf_mul(c[0], a[r]) ^ gf_mul(c[1], a[(r+1)%NROWS])
                                  ^ gf_mul(c[2], a[(r+2)%NROWS]) ^ gf_mul(c[3], a[(r+3)%NROWS]);
        end
        return res;
    endfunction
endpackage

// File: rtl/aes_sub_shift.sv
// aes_sub_shift: combined (Inv)ShiftRows and (Inv)SubBytes on a full block.
// INVERSE picks the decryption variant. The two steps commute, so each output
// byte is the substituted value of its row-rotated source byte.
module aes_sub_shift
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout
);
    for (genvar n = 0; n < NBYTES; n++) begin : g_byte
        localparam int ROW   = n % NROWS;
        localparam int COL   = n / NROWS;
        localparam int SRC_C = INVERSE ? (COL - ROW + NCOLS) % NCOLS : (COL + ROW) % NCOLS;
        localparam int SRC   = SRC_C * NROWS + ROW;
        if (INVERSE) begin : g_inv
            // inverse substitution of the right-rotated source byte
            assign dout[BLK_W-1-BYTE_W*n -: BYTE_W] = sbox_inv(din[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
        end else begin : g_fwd
            // forward substitution of the left-rotated source byte
            assign dout[BLK_W-1-BYTE_W*n -: BYTE_W] = sbox_fwd(din[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
        end
    end
endmodule

// File: rtl/aes_mix_cols.sv
// aes_mix_cols: MixColumns (INVERSE=0) or InvMixColumns (INVERSE=1) applied
// to every column of a block. Assumes column c holds bytes 4c..4c+3.
module aes_mix_cols
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BLK_W-1:0] din,
    output logic [BLK_W-1:0] dout
);
    for (genvar c = 0; c < NCOLS; c++) begin : g_col
        // mix one column independently of the others
        assign dout[BLK_W-1-COL_W*c -: COL_W] = col_mix(din[BLK_W-1-COL_W*c -: COL_W], INVERSE);
    end
endmodule

// File: rtl/aes_round_unit.sv
// aes_round_unit: one AES round step per accepted operand, selected by a
// 3-bit opcode that covers the fused and key-first conventions plus their
// inverses. The result is registered once and leaves through valid/ready.
// Assumes the caller supplies the expanded (and, for decryption, mixed) keys.
module aes_round_unit
    import aes_rnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OP_W-1:0]  in_op,
    input  logic [BLK_W-1:0] in_state,
    input  logic [BLK_W-1:0] in_key,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [BLK_W-1:0] out_data
);
    logic use_sub, use_mix, key_pre, key_post, inv;
    logic [BLK_W-1:0] pre_blk, fsub_blk, isub_blk, sub_blk;
    logic [BLK_W-1:0] fmix_blk, imix_blk, mix_blk, res_blk;

    // decode the opcode into datapath controls
    always_comb begin
        inv      = in_op[OP_W-1];
        use_sub  = 1'b1;
        use_mix  = 1'b0;
        key_pre  = 1'b0;
        key_post = 1'b0;
        case (in_op)
            OP_ENC, OP_DEC:         begin use_mix = 1'b1; key_post = 1'b1; end
            OP_ENCLAST, OP_DECLAST: key_post = 1'b1;
            OP_KFIRST, OP_KFIRSTI:  key_pre = 1'b1;
            default:                begin use_sub = 1'b0; use_mix = 1'b1; end
        endcase
    end

    // key XOR ahead of substitution for the key-first opcodes
    assign pre_blk = key_pre ? (in_state ^ in_key) : in_state;

    aes_sub_shift #(.INVERSE(1'b0)) u_fsub (.din(pre_blk), .dout(fsub_blk));
    aes_sub_shift #(.INVERSE(1'b1)) u_isub (.din(pre_blk), .dout(isub_blk));

    // choose direction, or bypass for the standalone mixing opcodes
    assign sub_blk = !use_sub ? pre_blk : (inv ? isub_blk : fsub_blk);

    aes_mix_cols #(.INVERSE(1'b0)) u_fmix (.din(sub_blk), .dout(fmix_blk));
    aes_mix_cols #(.INVERSE(1'b1)) u_imix (.din(sub_blk), .dout(imix_blk));

    // optional column mixing, then the trailing key XOR
    assign mix_blk = !use_mix ? sub_blk : (inv ? imix_blk : fmix_blk);
    assign res_blk = key_post ? (mix_blk ^ in_key) : mix_blk;

    // the slot may be refilled when it is empty or being drained
    assign in_ready = !out_valid || out_ready;

    // output valid flag with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)        out_valid <= 1'b0;
        else if (in_ready) out_valid <= in_valid;
    end

    // capture the result of an accepted operand
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) out_data <= res_blk;
    end
endmodule

// File: rtl/aes_round_unit_chk.sv
// aes_round_unit_chk: handshake properties of aes_round_unit, bound below.
module aes_round_unit_chk
    import aes_rnd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BLK_W-1:0] out_data
);
    // R12
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R10
    accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11
    stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind aes_round_unit aes_round_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_aes_round_unit.sv
// tb_aes_round_unit: directed known-answer rounds plus seeded random steps
// against bench-side models of every opcode.
module tb_aes_round_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_op = '0;
    logic [127:0] in_state = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] sb [256];
    logic [7:0] isb [256];
    logic [127:0] rk [11];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_round_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_state(in_state), .in_key(in_key),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_x2(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1B) : (a << 1);
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = m_x2(x);
        end
        return r;
    endfunction

    // build both tables by walking the generator 3 and its inverse
    task automatic build_sbox();
        logic [7:0] p = 8'h01;
        logic [7:0] q = 8'h01;
        logic [7:0] x;
        do begin
            p = p ^ m_x2(p);
            q = q ^ (q << 1); q = q ^ (q << 2); q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
            sb[p] = x ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
        for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
    endtask

    function automatic logic [7:0] gb(input logic [127:0] s, input int n);
        return s[127-8*n -: 8];
    endfunction

    function automatic logic [127:0] m_sub_shift(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        for (int n = 0; n < 16; n++) begin
            int r = n % 4;
            int c = n / 4;
            int src = inv ? (((c + 4 - r) % 4) * 4 + r) : (((c + r) % 4) * 4 + r);
            o[127-8*n -: 8] = inv ? isb[gb(s, src)] : sb[gb(s, src)];
        end
        return o;
    endfunction

    function automatic logic [127:0] m_mix(input logic [127:0] s, input bit inv);
        logic [127:0] o;
        logic [7:0] k0, k1, k2, k3;
        k0 = inv ? 8'h0E : 8'h02; k1 = inv ? 8'h0B : 8'h03;
        k2 = inv ? 8'h0D : 8'h01; k3 = inv ? 8'h09 : 8'h01;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[127-8*(4*c+r) -: 8] = m_mul(k0, gb(s, 4*c+r)) ^ m_mul(k1, gb(s, 4*c+(r+1)%4))
                                      ^ m_mul(k2, gb(s, 4*c+(r+2)%4)) ^ m_mul(k3, gb(s, 4*c+(r+3)%4));
        return o;
    endfunction

    function automatic logic [127:0] model(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k);
        bit inv = op[2];
        case (op[1:0])
            2'd0: return m_mix(m_sub_shift(s, inv), inv) ^ k;
            2'd1: return m_sub_shift(s, inv) ^ k;
            2'd2: return m_sub_shift(s ^ k, inv);
            default: return m_mix(s, inv);
        endcase
    endfunction

    task automatic expand_key(input logic [127:0] key);
        logic [31:0] w [44];
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t = w[i-1];
            if (i % 4 == 0) begin
                t = {sb[t[23:16]] ^ rc, sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
                rc = m_x2(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    endtask

    // one step through the handshake, stalling the output 'stall' cycles
    task automatic run_op(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k,
                          input int stall, output logic [127:0] res);
        logic [127:0] first;
        bit held = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_state = s; in_key = k; out_ready = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        // R10: result is present one cycle after acceptance
        check(out_valid === 1'b1, "R10 out_valid after accept", {127'd0, out_valid}, 128'd1);
        first = out_data;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            if (!(out_valid === 1'b1 && out_data === first && in_ready === 1'b0)) held = 1'b0;
        end
        // R11: held result and blocked input during a stall
        if (stall > 0) check(held, "R11 stall hold", out_data, first);
        res = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] r, r2, x, y, exp;
        logic [127:0] pt = 128'h00112233445566778899aabbccddeeff;
        logic [127:0] ct = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
        void'($urandom(32'd20240611));
        build_sbox();
        expand_key(128'h000102030405060708090a0b0c0d0e0f);
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid === 1'b0, "R12 out_valid in reset", {127'd0, out_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R12 idle after reset", {126'd0, in_ready, out_valid}, 128'd2);

        // R1: single nonzero byte at index 5 (row 1, col 1) moves to index 1 after ShiftRows
        run_op(3'd2, 128'h0000000000ff00000000000000000000, '0, 0, r);
        exp = {16{8'h63}}; exp[127-8*1 -: 8] = 8'h16;
        check(r === exp, "R1 byte mapping and row rotation", r, exp);

        // R9: fused convention, standard key example
        x = pt ^ rk[0];
        for (int i = 1; i < 10; i++) begin run_op(3'd0, x, rk[i], 0, x); end
        run_op(3'd1, x, rk[10], 1, x);
        check(x === ct, "R9 fused encrypt", x, ct);

        // R9: key-first convention with standalone mixing
        y = pt;
        for (int i = 0; i < 9; i++) begin
            run_op(3'd2, y, rk[i], 0, y);
            run_op(3'd3, y, 128'hdeadbeef, 0, y);
        end
        run_op(3'd2, y, rk[9], 2, y);
        y = y ^ rk[10];
        check(y === ct, "R9 key-first encrypt", y, ct);

        // R9: equivalent inverse cipher, both conventions
        x = ct ^ rk[10];
        for (int i = 9; i >= 1; i--) begin run_op(3'd4, x, m_mix(rk[i], 1'b1), 0, x); end
        run_op(3'd5, x, rk[0], 0, x);
        check(x === pt, "R9 fused decrypt", x, pt);
        y = ct;
        run_op(3'd6, y, rk[10], 0, y);
        for (int i = 9; i >= 1; i--) begin
            run_op(3'd7, y, '0, 0, y);
            run_op(3'd6, y, m_mix(rk[i], 1'b1), 0, y);
        end
        y = y ^ rk[0];
        check(y === pt, "R9 key-first decrypt", y, pt);

        // R5 R7: key ignored by the standalone mixing opcodes
        for (int op = 3; op <= 7; op += 4) begin
            x = {$urandom, $urandom, $urandom, $urandom};
            run_op(3'(op), x, '0, 0, r);
            run_op(3'(op), x, {4{32'hffffffff}}, 0, r2);
            check(r === r2 && r === model(3'(op), x, '0), op == 3 ? "R5 mix ignores key" : "R7 inv mix ignores key", r2, r);
        end

        // R8: identities between fused and split opcodes
        for (int i = 0; i < 8; i++) begin
            bit d = i[0];
            logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
            x = {$urandom, $urandom, $urandom, $urandom};
            run_op({d, 2'd2}, x, '0, 0, y);
            run_op({d, 2'd3}, y, k, 0, y);
            run_op({d, 2'd0}, x, k, 0, r);
            check(r === (y ^ k), "R8 full round identity", r, y ^ k);
            run_op({d, 2'd2}, x, '0, 0, y);
            run_op({d, 2'd1}, x, k, 0, r);
            check(r === (y ^ k), "R8 last round identity", r, y ^ k);
        end

        // R2 R3 R4 R5 R6 R7: random operands on every opcode with random stalls
        for (int i = 0; i < 160; i++) begin
            logic [2:0] op = 3'($urandom_range(0, 7));
            logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
            x = (i % 20 == 0) ? {16{8'hff}} : {$urandom, $urandom, $urandom, $urandom};
            run_op(op, x, k, $urandom_range(0, 2), r);
            exp = model(op, x, k);
            case (op)
                3'd0: check(r === exp, "R2 fused round", r, exp);
                3'd1: check(r === exp, "R3 fused last round", r, exp);
                3'd2: check(r === exp, "R4 key-first round", r, exp);
                3'd3: check(r === exp, "R5 mix columns", r, exp);
                3'd4, 3'd5: check(r === exp, "R6 inverse fused round", r, exp);
                default: check(r === exp, "R7 inverse key-first or mix", r, exp);
            endcase
        end

        // R12: synchronous reset drops a held result
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd0;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R12 reset clears held result", {127'd0, out_valid}, 128'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule